// File: doc/BRIEF.md
# Transform Pass Sequencer

This block steps an FFT engine through one transform job. A job is a window pass, then the radix-4 passes for the selected size, then an optional magnitude-squaring pass and an optional averaging pass. Every pass lasts a size-dependent number of cycles. The datapath is outside the block. The sequencer tells it when each pass begins, what kind of pass it is and which pass index is current, and it raises the end-of-transform flag once the results are ready.

There are two ways to launch a job. In single-shot mode, each cycle with the active-low start input low begins the job, or restarts it from the beginning. In continuous mode, jobs follow one another. With automatic throttling on, a job only begins when the input buffer holds a frame and one of the two output buffers can take a result. With throttling off, jobs begin regardless of buffer state and the user stalls the core with the hold input. Standby freezes the block in place. In filter mode the block runs a forward transform and then an inverse transform whose first pass is the coefficient multiply. It drives the inverse flag itself and reports completion only at the end of the second half.

The controller has three states. IDLE waits for a single-shot start. ARM waits for the continuous-mode start gate. RUN counts cycles and passes. Transitions:
- IDLE to ARM and ARM to IDLE follow the continuous-mode input.
- IDLE or ARM goes to RUN on a start pulse (single-shot) or on an open gate (continuous).
- RUN goes back to RUN on a restart pulse.
- RUN returns to IDLE or ARM on job completion.
- None of these transitions happens in a frozen cycle.

Top module: `xf_seq_ctrl`

## Requirements
- R1: Size code s (0..3, meaning 16/64/256/1024 points) gives 2+s radix-4 passes. Every pass lasts 4·4^s+15 cycles: 19, 31, 79 or 271. `pass_idx` counts passes from 0 within each transform half.
- R2: Pass order and kind codes are: window (0); the radix-4 passes (1); square (2) when `pwr_mode` is set; average (3) when `avg_en` is set. `pass_start` is high on exactly the first active cycle of each pass. A 1024-point averaged power job takes 8 passes and 2168 cycles.
- R3: With `cont_mode` low and the block not frozen, a cycle with `start_n` low puts the block in pass 0, cycle 0 on the next cycle. This also happens in the middle of a job, which restarts it.
- R4: `job_done` pulses on the last cycle of a job, and `eot` is high from the following cycle. In single-shot mode a start clears `eot`. In continuous mode `eot` clears when the window pass of the next job ends.
- R5: In continuous mode with `auto_thr` high, a job starts from ARM only in a cycle where `in_ready` and `obuf_room` are both high. `start_n` is ignored in continuous mode.
- R6: In continuous mode with `auto_thr` low, a job starts from ARM without regard to `in_ready` and `obuf_room`. `hold` freezes the core.
- R7: `auto_thr`, `in_ready` and `obuf_room` have no effect in single-shot mode.
- R8: The standby pair (`stdby`, `hold`) decodes as follows. `stdby` high freezes all state, with `pll_stop` low when `hold` is low (soft standby) and high when `hold` is high (hard standby). `hold` alone does not stall a single-shot job.
- R9: After a freeze, operation resumes from the same pass and cycle. A frozen cycle adds exactly one cycle to the job.
- R10: In filter mode the first half is the window pass plus the radix-4 passes with `inv_act` low. The second half is a kind-0 coefficient pass, the radix-4 passes and any output passes, with `inv_act` high. `job_done` fires only at the end of the second half.
- R11: Size, output mode, filter and inverse settings are captured when a job starts. Changing them mid-job has no effect on that job.
- R12: After reset the block is idle, `eot`, `job_done`, `pass_start` and `core_run` are low, and no pass runs until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cont_mode | input | 1 | 1 = continuous jobs, 0 = single-shot |
| start_n | input | 1 | Active-low start/restart (single-shot) |
| auto_thr | input | 1 | Automatic throttling in continuous mode |
| hold | input | 1 | Hold output buffer / stall free-run core |
| stdby | input | 1 | Standby: freeze everything |
| size_sel | input | 2 | Transform size code |
| pwr_mode | input | 1 | Add squaring pass |
| avg_en | input | 1 | Add averaging pass |
| filt_mode | input | 1 | Forward then inverse transform |
| inv_req | input | 1 | Inverse transform when not filtering |
| in_ready | input | 1 | Input buffer holds a full frame |
| obuf_room | input | 1 | At least one output buffer is free |
| pass_start | output | 1 | First active cycle of a pass |
| pass_kind | output | 2 | 0 window, 1 radix-4, 2 square, 3 average |
| pass_idx | output | 3 | Pass index within the current half |
| job_done | output | 1 | Last cycle of a job |
| eot | output | 1 | End-of-transform flag |
| inv_act | output | 1 | Inverse direction for the datapath |
| core_run | output | 1 | Core advancing this cycle |
| pll_stop | output | 1 | Clock multiplier stopped (hard standby) |

## Verification
The hardest cases to reach are those where state must survive a disturbance in the middle of a pass. One is a freeze partway through a pass, which must resume at the exact cycle. Another is an `eot` that is still high while the next continuous job's window pass runs and that must drop when that pass ends. To reach them, the stimulus launches a single-shot job, counts a fixed number of cycles, and then holds soft standby and then hard standby for ten cycles. It also leaves `eot` set from a filter job before switching into throttled continuous mode. There it holds the gate closed, first on the input side and then on the output side, before opening it. A behavioural model compares every output on every clock, so that each mid-pass cycle is checked.

// File: rtl/xf_seq_pkg.sv
package xf_seq_pkg;
    typedef enum logic [1:0] {
        K_WIN = 2'd0,
        K_R4  = 2'd1,
        K_SQR = 2'd2,
        K_AVG = 2'd3
    } pass_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] size;
        logic       pwr;
        logic       avg;
        logic       filt;
        logic       inv;
    } job_cfg_t;
endpackage

// File: rtl/xf_pass_plan.sv
module xf_pass_plan
    import xf_seq_pkg::*;
#(
    parameter int SZ_W   = 2,
    parameter int IDX_W  = 3,
    parameter int CYC_W  = 9,
    parameter int MIN_R4 = 2,
    parameter int Q0     = 4,
    parameter int OVH    = 15
) (
    input  logic [SZ_W-1:0]  size,
    input  logic             pwr,
    input  logic             avg,
    input  logic             filt,
    input  logic             half2,
    input  logic [IDX_W-1:0] pno,
    output logic [1:0]       kind,
    output logic             last,
    output logic [CYC_W-1:0] len
);
    localparam int TW = IDX_W + 1;

    logic [TW-1:0] n_r4, n_tail, total, pno_w;
    pass_kind_e    k;

    always_comb begin
        pno_w  = {1'b0, pno};
        n_r4   = TW'(MIN_R4) + TW'(size);
        n_tail = (filt && !half2) ? '0 : (TW'(pwr) + TW'(avg));
        total  = TW'(1) + n_r4 + n_tail;
        last   = (pno_w == total - TW'(1));
        if (pno_w == '0)                          k = K_WIN;
        else if (pno_w <= n_r4)                   k = K_R4;
        else if (pno_w == n_r4 + TW'(1) && pwr)   k = K_SQR;
        else                                      k = K_AVG;
        kind = k;
        len  = (CYC_W'(Q0) << {size, 1'b0}) + CYC_W'(OVH);
    end
endmodule

// File: rtl/xf_cycle_timer.sv
module xf_cycle_timer #(
    parameter int CYC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CYC_W-1:0] len,
    output logic [CYC_W-1:0] cyc,
    output logic             at_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cyc <= '0;
        else if (clr) cyc <= '0;
        else if (adv) cyc <= cyc + 1'b1;
    end

    assign at_end = (cyc == len - 1'b1);

    // R1
    cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc < len);
endmodule

// File: rtl/xf_seq_ctrl.sv
module xf_seq_ctrl
    import xf_seq_pkg::*;
#(
    parameter int SZ_W   = 2,
    parameter int IDX_W  = 3,
    parameter int CYC_W  = 9,
    parameter int MIN_R4 = 2,
    parameter int Q0     = 4,
    parameter int OVH    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cont_mode,
    input  logic             start_n,
    input  logic             auto_thr,
    input  logic             hold,
    input  logic             stdby,
    input  logic [SZ_W-1:0]  size_sel,
    input  logic             pwr_mode,
    input  logic             avg_en,
    input  logic             filt_mode,
    input  logic             inv_req,
    input  logic             in_ready,
    input  logic             obuf_room,
    output logic             pass_start,
    output logic [1:0]       pass_kind,
    output logic [IDX_W-1:0] pass_idx,
    output logic             job_done,
    output logic             eot,
    output logic             inv_act,
    output logic             core_run,
    output logic             pll_stop
);
    seq_state_e       state_q, state_d;
    job_cfg_t         cfg_q;
    logic             half2_q, eot_q;
    logic [IDX_W-1:0] pno_q;
    logic [CYC_W-1:0] cyc, len;
    logic             at_end, last;
    logic [1:0]       kind;
    logic             frz, gate, ss_go, cont_go, running;
    logic             pass_end, xf_end, job_end, half_flip;

    xf_pass_plan #(.SZ_W(SZ_W), .IDX_W(IDX_W), .CYC_W(CYC_W),
                   .MIN_R4(MIN_R4), .Q0(Q0), .OVH(OVH)) u_plan (
        .size(cfg_q.size), .pwr(cfg_q.pwr), .avg(cfg_q.avg), .filt(cfg_q.filt),
        .half2(half2_q), .pno(pno_q), .kind(kind), .last(last), .len(len)
    );

    xf_cycle_timer #(.CYC_W(CYC_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(ss_go || cont_go || pass_end),
        .adv(running && !at_end),
        .len(len), .cyc(cyc), .at_end(at_end)
    );

    always_comb begin
        frz       = stdby || (hold && cont_mode && !auto_thr);
        gate      = auto_thr ? (in_ready && obuf_room) : 1'b1;
        ss_go     = !cont_mode && !start_n && !frz;
        cont_go   = (state_q == S_ARM) && cont_mode && gate && !frz;
        running   = (state_q == S_RUN) && !frz;
        pass_end  = running && at_end;
        xf_end    = pass_end && last;
        half_flip = xf_end && cfg_q.filt && !half2_q;
        job_end   = xf_end && !half_flip;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (ss_go) state_d = S_RUN;
                    else if (cont_mode && !frz) state_d = S_ARM;
            S_ARM:  if (ss_go || cont_go) state_d = S_RUN;
                    else if (!cont_mode && !frz) state_d = S_IDLE;
            S_RUN:  if (ss_go) state_d = S_RUN;
                    else if (job_end) state_d = cont_mode ? S_ARM : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and job bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cfg_q   <= '0;
            half2_q <= 1'b0;
            pno_q   <= '0;
            eot_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ss_go || cont_go) begin
                cfg_q   <= '{size: size_sel, pwr: pwr_mode, avg: avg_en,
                             filt: filt_mode, inv: inv_req};
                half2_q <= 1'b0;
                pno_q   <= '0;
            end else if (pass_end) begin
                if (half_flip) begin
                    half2_q <= 1'b1;
                    pno_q   <= '0;
                end else if (!last) begin
                    pno_q <= pno_q + 1'b1;
                end
            end
            if (ss_go)
                eot_q <= 1'b0;
            else if (job_end)
                eot_q <= 1'b1;
            else if (pass_end && cont_mode && pno_q == '0 && !half2_q)
                eot_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        pass_start = running && (cyc == '0);
        pass_kind  = kind;
        pass_idx   = pno_q;
        job_done   = job_end;
        eot        = eot_q;
        inv_act    = cfg_q.filt ? half2_q : cfg_q.inv;
        core_run   = running;
        pll_stop   = stdby && hold;
    end

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_mode && !start_n && !frz) |=> (state_q == S_RUN && pass_idx == '0 && !eot));
    // R4
    eot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eot) |-> $past(job_done));
    // R5
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARM && cont_mode && auto_thr && !(in_ready && obuf_room)) |=> state_q != S_RUN);
    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stdby |=> ($stable(pass_idx) && $stable(eot) && $stable(state_q) && $stable(cyc)));
    // R8
    pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_stop |-> (stdby && !core_run));
    // R10
    filt_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (job_done && cfg_q.filt) |-> inv_act);
endmodule

// File: tb/xf_seq_ctrl_tb.sv
module xf_seq_ctrl_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cont_mode = 0, start_n = 1, auto_thr = 0, hold = 0, stdby = 0;
    logic [1:0] size_sel = 0;
    logic pwr_mode = 0, avg_en = 0, filt_mode = 0, inv_req = 0, in_ready = 0, obuf_room = 0;
    logic pass_start, job_done, eot, inv_act, core_run, pll_stop;
    logic [1:0] pass_kind;
    logic [2:0] pass_idx;

    int n_chk = 0, n_fail = 0, ev_ps = 0, wd = 0;
    int m_state = 0, m_pno = 0, m_cyc = 0, m_half = 0, m_eot = 0;
    int c_size = 0, c_pwr = 0, c_avg = 0, c_filt = 0, c_inv = 0;

    xf_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode), .start_n(start_n),
        .auto_thr(auto_thr), .hold(hold), .stdby(stdby), .size_sel(size_sel),
        .pwr_mode(pwr_mode), .avg_en(avg_en), .filt_mode(filt_mode), .inv_req(inv_req),
        .in_ready(in_ready), .obuf_room(obuf_room), .pass_start(pass_start),
        .pass_kind(pass_kind), .pass_idx(pass_idx), .job_done(job_done), .eot(eot),
        .inv_act(inv_act), .core_run(core_run), .pll_stop(pll_stop)
    );

    initial forever #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // reference model helpers
    function automatic int m_len();
        return (4 << (2 * c_size)) + 15;
    endfunction
    function automatic int m_total();
        int t;
        t = 3 + c_size;
        if (!(c_filt != 0 && m_half == 0)) t = t + c_pwr + c_avg;
        return t;
    endfunction
    function automatic int m_kind();
        if (m_pno == 0) return 0;
        if (m_pno <= 2 + c_size) return 1;
        if (m_pno == 3 + c_size && c_pwr != 0) return 2;
        return 3;
    endfunction
    function automatic bit m_frz();
        return stdby || (hold && cont_mode && !auto_thr);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int len, tot;
        bit frz, ssg, gte, cg;
        if (!rst_n) begin
            m_state = 0; m_pno = 0; m_cyc = 0; m_half = 0; m_eot = 0;
            c_size = 0; c_pwr = 0; c_avg = 0; c_filt = 0; c_inv = 0;
        end else begin
            len = m_len(); tot = m_total(); frz = m_frz();
            ssg = !cont_mode && !start_n && !frz;
            gte = auto_thr ? (in_ready && obuf_room) : 1'b1;
            cg  = (m_state == 1) && cont_mode && gte && !frz;
            if (ssg || cg) begin
                if (ssg) m_eot = 0;
                m_state = 2; m_pno = 0; m_cyc = 0; m_half = 0;
                c_size = size_sel; c_pwr = pwr_mode; c_avg = avg_en;
                c_filt = filt_mode; c_inv = inv_req;
            end else if (m_state == 2 && !frz) begin
                if (m_cyc == len - 1) begin
                    if (cont_mode && m_pno == 0 && m_half == 0) m_eot = 0;
                    m_cyc = 0;
                    if (m_pno == tot - 1) begin
                        if (c_filt != 0 && m_half == 0) begin m_half = 1; m_pno = 0; end
                        else begin m_state = cont_mode ? 1 : 0; m_eot = 1; end
                    end else m_pno++;
                end else m_cyc++;
            end else if (!frz) begin
                if (m_state == 0 && cont_mode) m_state = 1;
                else if (m_state == 1 && !cont_mode) m_state = 0;
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        bit run;
        #5;
        run = (m_state == 2) && !m_frz();
        if (pass_start) ev_ps++;
        chk("R2 pass_start", pass_start, (run && m_cyc == 0) ? 1 : 0);
        chk("R4 job_done", job_done,
            (run && m_cyc == m_len() - 1 && m_pno == m_total() - 1 && !(c_filt != 0 && m_half == 0)) ? 1 : 0);
        chk("R4 eot", eot, m_eot);
        chk("R9 core_run", core_run, run ? 1 : 0);
        chk("R10 inv_act", inv_act, (c_filt != 0) ? m_half : c_inv);
        chk("R8 pll_stop", pll_stop, (stdby && hold) ? 1 : 0);
        if (m_state == 2) begin
            chk("R2 pass_kind", pass_kind, m_kind());
            chk("R1 pass_idx", pass_idx, m_pno);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 60000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
            finish_run();
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_n = 0;
        @(negedge clk) start_n = 1;
        ev_ps = 0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        forever begin
            #6;
            n++;
            if (job_done === 1'b1 || n > 30000) break;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #6;
        chk("R12 reset eot", eot, 0);
        chk("R12 reset core_run", core_run, 0);
        chk("R12 reset pass_start", pass_start, 0);
        @(negedge clk) rst_n = 1;
        repeat (4) @(negedge clk);
        #6 chk("R12 idle without start", core_run, 0);

        // plain 16-point job
        pulse_start(); wait_done(n);
        chk("R1 16pt cycles", n, 57);
        chk("R2 16pt pass count", ev_ps, 3);

        // 1024-point averaged power
        @(negedge clk) begin size_sel = 3; pwr_mode = 1; avg_en = 1; end
        pulse_start(); wait_done(n);
        chk("R2 1024 avg power cycles", n, 2168);
        chk("R2 1024 avg power passes", ev_ps, 8);
        @(negedge clk);
        #6 chk("R4 eot after done", eot, 1);

        @(negedge clk) begin size_sel = 1; pwr_mode = 1; avg_en = 0; end
        pulse_start(); wait_done(n);
        chk("R1 64pt power cycles", n, 155);
        @(negedge clk) begin size_sel = 2; pwr_mode = 0; avg_en = 1; end
        pulse_start(); wait_done(n);
        chk("R1 256pt avg cycles", n, 474);

        // restart mid-job
        @(negedge clk) begin size_sel = 0; avg_en = 0; end
        pulse_start();
        repeat (10) @(negedge clk);
        #6 chk("R4 eot cleared by start", eot, 0);
        pulse_start(); wait_done(n);
        chk("R3 restart cycles", n, 57);

        // config change mid-job
        pulse_start();
        size_sel = 3; pwr_mode = 1; avg_en = 1;
        wait_done(n);
        chk("R11 captured config", n, 57);
        @(negedge clk) begin size_sel = 0; pwr_mode = 0; avg_en = 0; end

        // freeze: soft then hard standby
        pulse_start();
        repeat (5) @(negedge clk);
        stdby = 1;
        #6 chk("R8 soft standby stalls", core_run, 0);
        chk("R8 soft standby pll", pll_stop, 0);
        repeat (4) @(negedge clk);
        hold = 1;
        #6 chk("R8 hard standby pll", pll_stop, 1);
        repeat (6) @(negedge clk);
        stdby = 0; hold = 0;
        wait_done(n);
        chk("R9 resume remaining cycles", n, 52);

        // hold alone in single-shot
        @(negedge clk) hold = 1;
        pulse_start(); wait_done(n);
        chk("R8 hold no stall single-shot", n, 57);
        @(negedge clk) hold = 0;

        // throttle inputs ignored in single-shot
        @(negedge clk) begin auto_thr = 1; in_ready = 0; obuf_room = 0; end
        pulse_start(); wait_done(n);
        chk("R7 single-shot ungated", n, 57);

        // filter mode
        @(negedge clk) begin auto_thr = 0; filt_mode = 1; pwr_mode = 1; end
        pulse_start(); wait_done(n);
        chk("R10 filter cycles", n, 133);
        chk("R10 filter passes", ev_ps, 7);
        chk("R10 inverse at done", inv_act, 1);

        // continuous, throttled
        @(negedge clk) begin filt_mode = 0; pwr_mode = 0; cont_mode = 1; auto_thr = 1;
                             in_ready = 0; obuf_room = 1; end
        repeat (20) @(negedge clk);
        #6 chk("R5 waits for input", core_run, 0);
        @(negedge clk) begin in_ready = 1; obuf_room = 0; start_n = 0; end
        @(negedge clk) start_n = 1;
        repeat (5) @(negedge clk);
        #6 chk("R5 waits for output room, start ignored", core_run, 0);
        @(negedge clk) obuf_room = 1;
        @(negedge clk);
        #6 chk("R5 starts on open gate", core_run, 1);
        chk("R4 eot held during window pass", eot, 1);
        @(negedge clk) begin in_ready = 0; obuf_room = 0; end
        repeat (20) @(negedge clk);
        #6 chk("R4 eot cleared after window pass", eot, 0);
        @(negedge clk);
        wait_done(n);
        repeat (5) @(negedge clk);
        #6 chk("R5 gate closed after job", core_run, 0);

        // continuous free-run
        @(negedge clk) auto_thr = 0;
        @(negedge clk);
        #6 chk("R6 free-run starts ungated", core_run, 1);
        @(negedge clk) hold = 1;
        #6 chk("R6 hold stalls free-run", core_run, 0);
        repeat (3) @(negedge clk);
        hold = 0;
        wait_done(n);
        chk("R6 job completes after hold", job_done, 1);
        @(negedge clk) cont_mode = 0;
        repeat (60) @(negedge clk);
        finish_run();
    end
endmodule